// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block lets a host reach PCI configuration space through two small register ports. The first port is a 32-bit selector register. It names a bus, a device/function and a register offset, and its top bit arms the second port. The second port is a data window. The host can read or write 1, 2 or 4 bytes through it, and each access becomes one configuration request on the downstream side. That request carries the target coordinates, the byte offset, the length and the byte enables.

The host side is a valid/ready request channel followed by a valid/ready response channel. Every accepted request gets exactly one response, writes included. The host request ready is low from acceptance until the response is taken, so at most one access is in flight.

The downstream side is a valid/ready request channel with a completion that has no ready signal. Once the request handshake has happened, the bridge waits for exactly one completion pulse. The request fields stay constant while the request valid waits for ready.

Three presence inputs describe the device that the current selector points at:
- whether the device exists;
- whether it was hot-added;
- whether function 0 of the same device is present.

The bridge answers locally, and issues no downstream request, when:
- the window is disarmed;
- the offset lies outside the configuration space;
- the target is absent;
- the target is a hidden function.

In those cases a read returns all ones and a write is dropped.

Top module: `cfg_access_bridge`

## Requirements
- R1: A write to the selector port (h_req_sel=0) updates the selector register only when h_req_size is 4 and h_req_addr is 0. Any other selector write leaves the register unchanged. A selector access never issues a downstream request.
- R2: A read of the selector port returns the full 32-bit register value, whatever the requested size and byte address.
- R3: After reset the selector register is zero, h_req_ready is 1, and h_rsp_valid and c_req_valid are 0.
- R4: While selector bit 31 is 0, a data-window access (h_req_sel=1) issues no downstream request. A read then returns 32'hFFFFFFFF and a write is dropped.
- R5: A downstream request carries the bus from selector bits 23:16 and the device/function from bits 15:8. Its offset is selector bits 7:0 ORed with h_req_addr[1:0].
- R6: An access whose effective offset is at or above CFG_LIMIT issues no request. A read then returns 32'hFFFFFFFF and a write is dropped.
- R7: When c_dev_present is 0, a data-window access issues no request. A read then returns 32'hFFFFFFFF and a write is dropped.
- R8: A target is hidden when its function number (device/function bits 2:0) is non-zero, c_dev_hotadded is 1 and c_fn0_present is 0. A hidden target behaves as absent under R7.
- R9: The request length c_req_len is the smaller of the requested size and CFG_LIMIT minus the offset. Sizes other than 1 and 2 count as 4. Byte enable bit i is set when offset[1:0] <= i < offset[1:0] + length.
- R10: Write data is moved from byte lane 0 up to lane offset[1:0], and unenabled lanes are zero. The completion data is shifted down by offset[1:0] bytes and masked to c_req_len bytes before it is returned.
- R11: c_req_valid holds, with stable fields, until c_req_ready. No new downstream request or host request is accepted until the completion has arrived and the host has taken the response.
- R12: h_rsp_valid holds, with stable data, until h_rsp_ready. Every write response carries data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready (idle) |
| h_req_sel | input | 1 | 0 selects the selector port, 1 selects the data window |
| h_req_write | input | 1 | 1 for write, 0 for read |
| h_req_addr | input | 2 | Byte address within the port |
| h_req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| h_req_wdata | input | 32 | Write data, right-aligned |
| h_rsp_valid | output | 1 | Host response valid |
| h_rsp_ready | input | 1 | Host response ready |
| h_rsp_data | output | 32 | Read data, right-aligned; zero for writes |
| c_req_valid | output | 1 | Downstream request valid |
| c_req_ready | input | 1 | Downstream request ready |
| c_req_write | output | 1 | Downstream request is a write |
| c_req_bus | output | 8 | Target bus (also the presence lookup key) |
| c_req_devfn | output | 8 | Target device/function (also the presence lookup key) |
| c_req_off | output | 8 | Byte offset in configuration space |
| c_req_len | output | 3 | Access length in bytes |
| c_req_be | output | 4 | Byte enables within the dword |
| c_req_wdata | output | 32 | Lane-placed write data |
| c_cpl_valid | input | 1 | Completion pulse for the outstanding request |
| c_cpl_data | input | 32 | Completion dword |
| c_dev_present | input | 1 | Device at c_req_bus/c_req_devfn exists |
| c_dev_hotadded | input | 1 | That device was hot-added |
| c_fn0_present | input | 1 | Function 0 of that device is present |

## Verification
The bench builds the bridge with CFG_LIMIT set to 254 instead of 256. With this value, offsets 0xFE and 0xFF lie beyond the space and must be refused. The offsets 0xFB and 0xFD still clip a 4-byte request to 3 and 1 bytes. The default value could not reach the out-of-range refusal at all, because an 8-bit offset never exceeds 255. The stall cases hold both ready inputs low for several cycles. This checks that the request fields and the response data stay frozen while back-pressure is applied.

// File: rtl/cab_pkg.sv
package cab_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int FIELD_W = 8;
  localparam int LEN_W   = LANE_W + 1;
  localparam int LIM_W   = FIELD_W + 1;
  localparam int EN_BIT  = DATA_W - 1;
  localparam int BUS_LO  = 2 * FIELD_W;
  localparam int DEV_LO  = FIELD_W;
  localparam int FN_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DSREQ = 2'd1,
    ST_DSWAIT = 2'd2,
    ST_RESP = 2'd3
  } cab_state_e;

  typedef struct packed {
    logic               write;
    logic [FIELD_W-1:0] off;
    logic [LEN_W-1:0]   len;
    logic [LANES-1:0]   be;
    logic [DATA_W-1:0]  wdata;
  } cab_txn_t;
endpackage

// File: rtl/cab_addr_reg.sv
module cab_addr_reg
  import cab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  q,
  output logic               armed,
  output logic [FIELD_W-1:0] bus,
  output logic [FIELD_W-1:0] devfn,
  output logic [FIELD_W-1:0] reg_off
);
  logic [DATA_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= wr_data;
    end
  end

  assign q       = sel_q;
  assign armed   = sel_q[EN_BIT];
  assign bus     = sel_q[BUS_LO +: FIELD_W];
  assign devfn   = sel_q[DEV_LO +: FIELD_W];
  assign reg_off = sel_q[0 +: FIELD_W];
endmodule

// File: rtl/cab_decode.sv
module cab_decode
  import cab_pkg::*;
#(
  parameter int CFG_LIMIT = 256
) (
  input  logic               armed,
  input  logic [FIELD_W-1:0] devfn,
  input  logic [FIELD_W-1:0] reg_off,
  input  logic [LANE_W-1:0]  host_addr,
  input  logic [2:0]         host_size,
  input  logic               present,
  input  logic               hotadded,
  input  logic               fn0_present,
  output logic [FIELD_W-1:0] eff_off,
  output logic [LEN_W-1:0]   len,
  output logic [LANES-1:0]   be,
  output logic               go
);
  localparam logic [LIM_W-1:0] LIMIT_V = LIM_W'(CFG_LIMIT);

  logic [LEN_W-1:0] size_n;
  logic [LIM_W-1:0] off_ext;
  logic [LIM_W-1:0] remain;
  logic             in_range;
  logic             hidden;
  logic [LEN_W:0]   lane_end;

  assign eff_off = reg_off | {{(FIELD_W-LANE_W){1'b0}}, host_addr};
  assign off_ext = {1'b0, eff_off};
  assign in_range = off_ext < LIMIT_V;
  assign remain = in_range ? (LIMIT_V - off_ext) : '0;

  always_comb begin
    case (host_size)
      3'd1:    size_n = LEN_W'(1);
      3'd2:    size_n = LEN_W'(2);
      default: size_n = LEN_W'(LANES);
    endcase
  end

  always_comb begin
    if (remain < {{(LIM_W-LEN_W){1'b0}}, size_n}) begin
      len = remain[LEN_W-1:0];
    end else begin
      len = size_n;
    end
  end

  assign hidden = (devfn[FN_W-1:0] != '0) && hotadded && !fn0_present;
  assign go = armed && in_range && present && !hidden;

  assign lane_end = {1'b0, {(LEN_W-LANE_W){1'b0}}, eff_off[LANE_W-1:0]} + {1'b0, len};

  for (genvar gi = 0; gi < LANES; gi++) begin : g_be
    localparam logic [LEN_W:0] IDX = (LEN_W+1)'(gi);
    assign be[gi] = (IDX >= {{(LEN_W+1-LANE_W){1'b0}}, eff_off[LANE_W-1:0]}) && (IDX < lane_end);
  end
endmodule

// File: rtl/cab_lane.sv
module cab_lane
  import cab_pkg::*;
(
  input  logic [LANE_W-1:0] wr_start,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] wr_lanes,
  input  logic [LANE_W-1:0] rd_start,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [DATA_W-1:0] rd_lanes,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_wr
    logic [LANE_W-1:0] src;
    assign src = LANE_W'(gi) - wr_start;
    assign wr_lanes[8*gi +: 8] = wr_be[gi] ? wr_data[8*src +: 8] : 8'h00;
  end

  for (genvar gj = 0; gj < LANES; gj++) begin : g_rd
    logic [LANE_W:0] src;
    logic            keep;
    assign src  = (LANE_W+1)'(gj) + {1'b0, rd_start};
    assign keep = (LEN_W'(gj) < rd_len) && (src < (LANE_W+1)'(LANES));
    assign rd_data[8*gj +: 8] = keep ? rd_lanes[8*src[LANE_W-1:0] +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cab_pkg::*;
#(
  parameter int CFG_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_req_valid,
  output logic        h_req_ready,
  input  logic        h_req_sel,
  input  logic        h_req_write,
  input  logic [1:0]  h_req_addr,
  input  logic [2:0]  h_req_size,
  input  logic [31:0] h_req_wdata,
  output logic        h_rsp_valid,
  input  logic        h_rsp_ready,
  output logic [31:0] h_rsp_data,
  output logic        c_req_valid,
  input  logic        c_req_ready,
  output logic        c_req_write,
  output logic [7:0]  c_req_bus,
  output logic [7:0]  c_req_devfn,
  output logic [7:0]  c_req_off,
  output logic [2:0]  c_req_len,
  output logic [3:0]  c_req_be,
  output logic [31:0] c_req_wdata,
  input  logic        c_cpl_valid,
  input  logic [31:0] c_cpl_data,
  input  logic        c_dev_present,
  input  logic        c_dev_hotadded,
  input  logic        c_fn0_present
);
  cab_state_e st_q;
  cab_txn_t   txn_q;
  logic [DATA_W-1:0] rsp_q;

  logic [DATA_W-1:0]  cfg_q;
  logic               cfg_armed;
  logic [FIELD_W-1:0] cfg_bus, cfg_devfn, cfg_off;
  logic               accept;
  logic               sel_wr_ok;

  logic [FIELD_W-1:0] dec_off;
  logic [LEN_W-1:0]   dec_len;
  logic [LANES-1:0]   dec_be;
  logic               dec_go;
  logic [DATA_W-1:0]  lane_wdata;
  logic [DATA_W-1:0]  aligned_rd;

  assign accept    = (st_q == ST_IDLE) && h_req_valid;
  assign sel_wr_ok = accept && !h_req_sel && h_req_write &&
                     (h_req_size == 3'd4) && (h_req_addr == 2'd0);

  cab_addr_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr_ok),
    .wr_data (h_req_wdata),
    .q       (cfg_q),
    .armed   (cfg_armed),
    .bus     (cfg_bus),
    .devfn   (cfg_devfn),
    .reg_off (cfg_off)
  );

  cab_decode #(.CFG_LIMIT(CFG_LIMIT)) u_dec (
    .armed       (cfg_armed),
    .devfn       (cfg_devfn),
    .reg_off     (cfg_off),
    .host_addr   (h_req_addr),
    .host_size   (h_req_size),
    .present     (c_dev_present),
    .hotadded    (c_dev_hotadded),
    .fn0_present (c_fn0_present),
    .eff_off     (dec_off),
    .len         (dec_len),
    .be          (dec_be),
    .go          (dec_go)
  );

  cab_lane u_lane (
    .wr_start (dec_off[LANE_W-1:0]),
    .wr_be    (dec_be),
    .wr_data  (h_req_wdata),
    .wr_lanes (lane_wdata),
    .rd_start (txn_q.off[LANE_W-1:0]),
    .rd_len   (txn_q.len),
    .rd_lanes (c_cpl_data),
    .rd_data  (aligned_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      txn_q <= '0;
      rsp_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (h_req_valid) begin
            if (!h_req_sel) begin
              rsp_q <= h_req_write ? '0 : cfg_q;
              st_q  <= ST_RESP;
            end else if (dec_go) begin
              txn_q.write <= h_req_write;
              txn_q.off   <= dec_off;
              txn_q.len   <= dec_len;
              txn_q.be    <= dec_be;
              txn_q.wdata <= h_req_write ? lane_wdata : '0;
              st_q        <= ST_DSREQ;
            end else begin
              rsp_q <= h_req_write ? '0 : '1;
              st_q  <= ST_RESP;
            end
          end
        end
        ST_DSREQ: begin
          if (c_req_ready) begin
            st_q <= ST_DSWAIT;
          end
        end
        ST_DSWAIT: begin
          if (c_cpl_valid) begin
            rsp_q <= txn_q.write ? '0 : aligned_rd;
            st_q  <= ST_RESP;
          end
        end
        default: begin
          if (h_rsp_ready) begin
            st_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign h_req_ready = (st_q == ST_IDLE);
  assign h_rsp_valid = (st_q == ST_RESP);
  assign h_rsp_data  = rsp_q;
  assign c_req_valid = (st_q == ST_DSREQ);
  assign c_req_write = txn_q.write;
  assign c_req_bus   = cfg_bus;
  assign c_req_devfn = cfg_devfn;
  assign c_req_off   = txn_q.off;
  assign c_req_len   = txn_q.len;
  assign c_req_be    = txn_q.be;
  assign c_req_wdata = txn_q.wdata;
endmodule

// File: rtl/cab_checker.sv
module cab_checker #(
  parameter int CFG_LIMIT = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        h_req_ready,
  input logic        h_rsp_valid,
  input logic        h_rsp_ready,
  input logic [31:0] h_rsp_data,
  input logic        c_req_valid,
  input logic        c_req_ready,
  input logic [7:0]  c_req_off,
  input logic [2:0]  c_req_len,
  input logic [3:0]  c_req_be,
  input logic [31:0] c_req_wdata,
  input logic        sel_armed
);
  localparam logic [8:0] LIMIT_V = 9'(CFG_LIMIT);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req_valid && !c_req_ready) |=> (c_req_valid && $stable(c_req_off) &&
    $stable(c_req_be) && $stable(c_req_wdata))); // R11
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> !h_req_ready); // R11
  AST_NO_REQ_DURING_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |-> !c_req_valid); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && !h_rsp_ready) |=> (h_rsp_valid && $stable(h_rsp_data))); // R12
  AST_REQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> sel_armed); // R4
  AST_REQ_IN_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> ({1'b0, c_req_off} < LIMIT_V)); // R6
  AST_BE_FITS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    c_req_valid |-> (($countones(c_req_be) <= int'(c_req_len)) && (c_req_len != 3'd0))); // R9
endmodule

bind cfg_access_bridge cab_checker #(.CFG_LIMIT(CFG_LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_ready (h_req_ready),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_ready (h_rsp_ready),
  .h_rsp_data  (h_rsp_data),
  .c_req_valid (c_req_valid),
  .c_req_ready (c_req_ready),
  .c_req_off   (c_req_off),
  .c_req_len   (c_req_len),
  .c_req_be    (c_req_be),
  .c_req_wdata (c_req_wdata),
  .sel_armed   (cfg_armed)
);

// File: tb/cfg_access_bridge_tb_top.sv
module cfg_access_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req_valid = 1'b0, h_req_sel = 1'b0, h_req_write = 1'b0;
  logic [1:0]  h_req_addr = '0;
  logic [2:0]  h_req_size = '0;
  logic [31:0] h_req_wdata = '0;
  logic        h_req_ready, h_rsp_valid;
  logic        h_rsp_ready = 1'b0;
  logic [31:0] h_rsp_data;
  logic        c_req_valid, c_req_write;
  logic        c_req_ready = 1'b0;
  logic [7:0]  c_req_bus, c_req_devfn, c_req_off;
  logic [2:0]  c_req_len;
  logic [3:0]  c_req_be;
  logic [31:0] c_req_wdata;
  logic        c_cpl_valid = 1'b0;
  logic [31:0] c_cpl_data = '0;
  logic        c_dev_present = 1'b1, c_dev_hotadded = 1'b0, c_fn0_present = 1'b1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_access_bridge #(.CFG_LIMIT(254)) dut_i (.*);

  typedef struct packed {
    logic [31:0] cfg;
    logic        wr;
    logic [1:0]  a;
    logic [2:0]  sz;
    logic [31:0] wd;
    logic [31:0] cpl;
    logic        pres;
    logic        hot;
    logic        fn0;
    logic        xds;
    logic [7:0]  xoff;
    logic [2:0]  xlen;
    logic [3:0]  xbe;
    logic [31:0] xdat;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h8001_0800, 1'b0, 2'd0, 3'd4, 32'h0, 32'h1122_3344, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 3'd4, 4'hF, 32'h1122_3344},
    '{32'h8001_0800, 1'b0, 2'd2, 3'd1, 32'h0, 32'h1122_3344, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 3'd1, 4'h4, 32'h0000_0022},
    '{32'h8001_0810, 1'b0, 2'd2, 3'd2, 32'h0, 32'hA1B2_C3D4, 1'b1, 1'b0, 1'b0, 1'b1, 8'h12, 3'd2, 4'hC, 32'h0000_A1B2},
    '{32'h8002_0004, 1'b1, 2'd3, 3'd1, 32'h0000_00AB, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 3'd1, 4'h8, 32'hAB00_0000},
    '{32'h8000_0020, 1'b1, 2'd0, 3'd2, 32'h0000_1234, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 3'd2, 4'h3, 32'h0000_1234},
    '{32'h0001_0800, 1'b0, 2'd0, 3'd4, 32'h0, 32'h5555_5555, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'hFFFF_FFFF},
    '{32'h0001_0800, 1'b1, 2'd0, 3'd4, 32'hCAFE_F00D, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'h0},
    '{32'h8003_1000, 1'b0, 2'd0, 3'd4, 32'h0, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'hFFFF_FFFF},
    '{32'h8003_0900, 1'b0, 2'd0, 3'd4, 32'h0, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'hFFFF_FFFF},
    '{32'h8003_0900, 1'b0, 2'd0, 3'd4, 32'h0, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 3'd4, 4'hF, 32'h0BAD_F00D},
    '{32'h8003_0800, 1'b0, 2'd1, 3'd1, 32'h0, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 3'd1, 4'h2, 32'h0000_00F0},
    '{32'h8003_0A00, 1'b1, 2'd0, 3'd4, 32'h1111_1111, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'h0},
    '{32'h8000_00FC, 1'b0, 2'd1, 3'd4, 32'h0, 32'h4433_2211, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFD, 3'd1, 4'h2, 32'h0000_0022},
    '{32'h8000_00FC, 1'b0, 2'd2, 3'd4, 32'h0, 32'h4433_2211, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'hFFFF_FFFF},
    '{32'h8000_00FC, 1'b1, 2'd3, 3'd1, 32'h0000_0077, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0, 32'h0},
    '{32'h8000_00FB, 1'b0, 2'd0, 3'd4, 32'h0, 32'h4433_2211, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFB, 3'd3, 4'h8, 32'h0000_0044},
    '{32'h8000_0041, 1'b0, 2'd2, 3'd1, 32'h0, 32'h4433_2211, 1'b1, 1'b0, 1'b0, 1'b1, 8'h43, 3'd1, 4'h8, 32'h0000_0044},
    '{32'h8005_2040, 1'b0, 2'd2, 3'd4, 32'h0, 32'h4433_2211, 1'b1, 1'b0, 1'b0, 1'b1, 8'h42, 3'd4, 4'hC, 32'h0000_4433},
    '{32'h8000_00FA, 1'b1, 2'd0, 3'd4, 32'hDEAD_BEEF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFA, 3'd4, 4'hC, 32'hBEEF_0000}
  };

  logic        cap_wr;
  logic [7:0]  cap_bus, cap_devfn, cap_off;
  logic [2:0]  cap_len;
  logic [3:0]  cap_be;
  logic [31:0] cap_wd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic wr, input logic [1:0] a,
                        input logic [2:0] sz, input logic [31:0] wd, input logic [31:0] cpl,
                        input int ds_stall, input int rs_stall,
                        output logic ds_seen, output logic [31:0] rsp);
    bit done = 0;
    ds_seen = 0;
    rsp = '0;
    @(negedge clk);
    h_req_valid = 1'b1; h_req_sel = sel; h_req_write = wr;
    h_req_addr = a; h_req_size = sz; h_req_wdata = wd;
    @(posedge clk);
    #1 h_req_valid = 1'b0;
    for (int t = 0; t < 60 && !done; t++) begin
      @(negedge clk);
      if (c_req_valid && !ds_seen) begin
        ds_seen = 1;
        cap_wr = c_req_write; cap_bus = c_req_bus; cap_devfn = c_req_devfn;
        cap_off = c_req_off; cap_len = c_req_len; cap_be = c_req_be; cap_wd = c_req_wdata;
        if (h_req_ready) chk("R11 host ready while busy", 32'(h_req_ready), 32'h0);
        for (int s = 0; s < ds_stall; s++) begin
          @(negedge clk);
          chk("R11 request held under stall", {c_req_valid, c_req_off, c_req_be, c_req_len},
              {1'b1, cap_off, cap_be, cap_len});
        end
        c_req_ready = 1'b1;
        @(negedge clk);
        c_req_ready = 1'b0;
        if (c_req_valid) chk("R11 single outstanding", 32'(c_req_valid), 32'h0);
        c_cpl_valid = 1'b1; c_cpl_data = cpl;
        @(negedge clk);
        c_cpl_valid = 1'b0;
      end
      if (h_rsp_valid) begin
        rsp = h_rsp_data;
        for (int s = 0; s < rs_stall; s++) begin
          @(negedge clk);
          chk("R12 response held under stall", {h_rsp_valid, h_rsp_data}, {1'b1, rsp});
        end
        h_rsp_ready = 1'b1;
        @(negedge clk);
        h_rsp_ready = 1'b0;
        done = 1;
      end
    end
    if (!done) chk("R11 response never arrived", 32'h0, 32'h1);
  endtask

  task automatic set_sel(input logic [31:0] v);
    logic d; logic [31:0] r;
    access(1'b0, 1'b1, 2'd0, 3'd4, v, 32'h0, 0, 0, d, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R11 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ds; logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3 reset state
    @(negedge clk);
    chk("R3 h_req_ready", 32'(h_req_ready), 32'h1);
    chk("R3 h_rsp_valid", 32'(h_rsp_valid), 32'h0);
    chk("R3 c_req_valid", 32'(c_req_valid), 32'h0);
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, 32'h0, 0, 0, ds, r);
    chk("R3 selector after reset", r, 32'h0);

    // R1 / R2 selector port
    access(1'b0, 1'b1, 2'd0, 3'd4, 32'h8012_3456, 32'h0, 0, 0, ds, r);
    chk("R1 selector write no downstream", 32'(ds), 32'h0);
    access(1'b0, 1'b0, 2'd2, 3'd1, 32'h0, 32'h0, 0, 0, ds, r);
    chk("R2 selector read size 1", r, 32'h8012_3456);
    access(1'b0, 1'b1, 2'd0, 3'd2, 32'h0000_FFFF, 32'h0, 0, 0, ds, r);
    access(1'b0, 1'b0, 2'd0, 3'd4, 32'h0, 32'h0, 0, 0, ds, r);
    chk("R1 size-2 selector write ignored", r, 32'h8012_3456);
    access(1'b0, 1'b1, 2'd1, 3'd4, 32'h0BAD_0BAD, 32'h0, 0, 0, ds, r);
    access(1'b0, 1'b0, 2'd3, 3'd2, 32'h0, 32'h0, 0, 0, ds, r);
    chk("R1 offset-1 selector write ignored", r, 32'h8012_3456);

    // vector table
    for (int i = 0; i < NV; i++) begin
      c_dev_present = VECS[i].pres;
      c_dev_hotadded = VECS[i].hot;
      c_fn0_present = VECS[i].fn0;
      set_sel(VECS[i].cfg);
      access(1'b1, VECS[i].wr, VECS[i].a, VECS[i].sz, VECS[i].wd, VECS[i].cpl, 0, 0, ds, r);
      chk("R4/R6/R7/R8 downstream issued", 32'(ds), 32'(VECS[i].xds));
      if (ds && VECS[i].xds) begin
        chk("R5 bus", 32'(cap_bus), 32'(VECS[i].cfg[23:16]));
        chk("R5 devfn", 32'(cap_devfn), 32'(VECS[i].cfg[15:8]));
        chk("R5 offset", 32'(cap_off), 32'(VECS[i].xoff));
        chk("R9 length", 32'(cap_len), 32'(VECS[i].xlen));
        chk("R9 byte enables", 32'(cap_be), 32'(VECS[i].xbe));
        chk("R5 write flag", 32'(cap_wr), 32'(VECS[i].wr));
        if (VECS[i].wr) chk("R10 write lanes", cap_wd, VECS[i].xdat);
      end
      if (VECS[i].wr) chk("R12 write response zero", r, 32'h0);
      else chk("R10 read data", r, VECS[i].xdat);
    end

    // R11 / R12 back-pressure
    c_dev_present = 1'b1; c_dev_hotadded = 1'b0; c_fn0_present = 1'b1;
    set_sel(32'h8007_1830);
    access(1'b1, 1'b0, 2'd1, 3'd2, 32'h0, 32'h8877_6655, 3, 4, ds, r);
    chk("R11 stalled request issued", 32'(ds), 32'h1);
    chk("R10 stalled read data", r, 32'h0000_7766);
    chk("R5 stalled offset", 32'(cap_off), 32'h31);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule